// File: doc/BRIEF.md
# Triggered Gated Timer Channel

This block is one counting channel of a general timer. A prescaled clock (the system clock divided by two) drives a counter that is 16 bits wide by default. A secondary input, taken from one of four shared external pins, starts the count on its rising edge. The block can latch the count on the input's next falling edge, which gives a direct measurement of an external pulse width. In a third mode the same trigger shapes an output pulse that is shorter than the incoming one.

Free-running mode gives a periodic compare event. The counter runs from zero up to the compare value and then reloads. Two sticky flags record compare events and capture events. Each flag is cleared by a one-cycle write-one-to-clear strobe and can be routed to a single interrupt/request line.

Top module: `trig_timer_ch`

## Requirements
- R1: While `enable_i` is high, the counter advances by one on every second clock edge. Taking edge 0 as the first edge that samples `enable_i` high, the counter advances on edges 1, 3, 5 and so on. While `enable_i` is low, the counter is cleared to 0 and does not advance.
- R2: The secondary source is `pins_i[pin_sel_i]`, passed through a two-flop synchronizer. A level first sampled at edge a takes effect at edge a+2. Edges on pins that are not selected have no effect.
- R3: In mode 0 (free), the counter runs through 0..`cmp_val_i`. On an advancing edge where the counter equals `cmp_val_i`, the counter reloads to 0 and the compare flag is set.
- R4: In modes 1, 2 and 3 (triggered), the counter starts at 0 after enable and holds while armed. The first secondary rising edge reloads the counter to 0 and starts counting. The next secondary falling edge stops the count without advancing it and re-arms the channel.
- R5: With `cap_en_i`=1, the falling edge that stops a triggered count copies the counter into `cap_val_o` and sets the edge flag. With `cap_en_i`=0, `cap_val_o` and the edge flag are left unchanged.
- R6: If no falling edge arrives, the running counter wraps from its maximum value to 0 and keeps counting, and no capture takes place.
- R7: In triggered modes, an advancing edge where the counter equals `cmp_val_i` sets the compare flag, and the counter continues.
- R8: In mode 2 (pulse shortening), `out_o` is cleared at the trigger, set at a compare event and cleared at the stopping falling edge. A falling edge wins over a compare event on the same edge. In every other mode, and while disabled, `out_o` is 0.
- R9: Flags are sticky. `flag_clr_i` bit 0 clears the compare flag and bit 1 clears the edge flag. A flag being set wins over a clear in the same cycle.
- R10: `irq_o` is high when the compare flag is set with `irq_en_i` bit 0 high, or when the edge flag is set with `irq_en_i` bit 1 high.
- R11: During reset and after it, the counter, the capture value, both flags, `irq_o` and `out_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | PIN_N | Shared external input pins |
| pin_sel_i | input | SEL_W | Index of the pin used as secondary source |
| mode_i | input | 2 | 0 free, 1 capture, 2 pulse shortening, 3 capture |
| enable_i | input | 1 | Channel enable |
| cmp_val_i | input | CNT_W | Compare value |
| cap_en_i | input | 1 | Capture on falling edge enable |
| irq_en_i | input | 2 | Interrupt enables: bit 0 compare, bit 1 edge |
| flag_clr_i | input | 2 | Write-one-to-clear strobes: bit 0 compare, bit 1 edge |
| cnt_o | output | CNT_W | Current counter value |
| cap_val_o | output | CNT_W | Captured counter value |
| cmp_flag_o | output | 1 | Sticky compare flag |
| edge_flag_o | output | 1 | Sticky capture/edge flag |
| irq_o | output | 1 | Interrupt/request line |
| out_o | output | 1 | Shaped output signal |

## Verification
The hardest situations to reach from the ports are the full counter wrap, which needs the input held high for a whole counter range, and the alignment of a pulse edge against the divide-by-two phase. The bench builds the channel with an 8-bit counter so that a wrap takes only about five hundred cycles. It also starts every pulse on both phases of the prescaler and sweeps pulse widths and compare values. The expected capture value and output waveform are derived by counting odd edges between the trigger and the stop.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
  typedef enum logic [1:0] {
    MODE_FREE        = 2'd0,
    MODE_CAPTURE     = 2'd1,
    MODE_SHORTEN     = 2'd2,
    MODE_CAPTURE_ALT = 2'd3
  } tmr_mode_e;

  localparam int FLAG_N    = 2;
  localparam int FLAG_CMP  = 0;
  localparam int FLAG_EDGE = 1;
endpackage

// File: rtl/trig_timer_insync.sv
module trig_timer_insync #(
  parameter int PIN_N  = 4,
  parameter int SEL_W  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_N-1:0] pins_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o,
  output logic             fall_o
);
  // chain[0..STAGES-1] synchronizer, chain[STAGES] previous synced level
  logic [STAGES:0] chain_q, chain_d;
  logic            raw;

  always_comb begin
    raw     = pins_i[sel_i];
    chain_d = {chain_q[STAGES-1:0], raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  always_comb begin
    rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/trig_timer_prescale.sv
module trig_timer_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  logic phase_q, phase_d;

  always_comb phase_d = en_i ? ~phase_q : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign tick_o = en_i & phase_q;
endmodule

// File: rtl/trig_timer_core.sv
module trig_timer_core
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  tmr_mode_e        mode_i,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             cap_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             cmp_evt_o,
  output logic             cap_evt_o,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic             run_q, run_d, out_q, out_d;
  logic             trig_mode, shorten, start, stop, adv, hit;

  always_comb begin
    trig_mode = (mode_i != MODE_FREE);
    shorten   = (mode_i == MODE_SHORTEN);
    start     = en_i & trig_mode & ~run_q & rise_i;
    stop      = en_i & trig_mode & run_q & fall_i;
    // advancing edge: free mode on every tick, triggered only while running
    adv       = en_i & tick_i & (trig_mode ? (run_q & ~fall_i) : 1'b1);
    hit       = adv & (cnt_q == cmp_i);

    cnt_d = cnt_q;
    run_d = run_q;
    cap_d = cap_q;
    out_d = out_q;

    if (!en_i) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (!trig_mode) begin
      run_d = 1'b0;
      if (adv) cnt_d = hit ? '0 : cnt_q + CNT_ONE;
    end else if (start) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (stop) begin
      run_d = 1'b0;
    end else if (adv) begin
      cnt_d = cnt_q + CNT_ONE;
    end

    if (stop && cap_en_i) cap_d = cnt_q;

    if (!en_i || !shorten) out_d = 1'b0;
    else if (start || stop) out_d = 1'b0;
    else if (hit)           out_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      run_q <= run_d;
      out_q <= out_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cap_o     = cap_q;
  assign cmp_evt_o = hit;
  assign cap_evt_o = stop & cap_en_i;
  assign out_o     = out_q;
endmodule

// File: rtl/trig_timer_flags.sv
module trig_timer_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);
endmodule

// File: rtl/trig_timer_ch.sv
module trig_timer_ch
  import trig_timer_pkg::*;
#(
  parameter int  CNT_W = 16,
  parameter int  PIN_N = 4,
  localparam int SEL_W = (PIN_N > 1) ? $clog2(PIN_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_N-1:0] pins_i,
  input  logic [SEL_W-1:0] pin_sel_i,
  input  logic [1:0]       mode_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             cap_en_i,
  input  logic [1:0]       irq_en_i,
  input  logic [1:0]       flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cmp_flag_o,
  output logic             edge_flag_o,
  output logic             irq_o,
  output logic             out_o
);
  tmr_mode_e         mode_e;
  logic              tick, rise, fall, cmp_evt, cap_evt;
  logic [FLAG_N-1:0] flag_set, flags;

  always_comb mode_e = tmr_mode_e'(mode_i);

  trig_timer_insync #(.PIN_N(PIN_N), .SEL_W(SEL_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .sel_i(pin_sel_i),
    .rise_o(rise), .fall_o(fall)
  );

  trig_timer_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .en_i(enable_i), .tick_o(tick)
  );

  trig_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en_i(enable_i), .mode_i(mode_e),
    .tick_i(tick), .rise_i(rise), .fall_i(fall), .cmp_i(cmp_val_i),
    .cap_en_i(cap_en_i), .cnt_o(cnt_o), .cap_o(cap_val_o),
    .cmp_evt_o(cmp_evt), .cap_evt_o(cap_evt), .out_o(out_o)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_CMP]  = cmp_evt;
    flag_set[FLAG_EDGE] = cap_evt;
  end

  trig_timer_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr_i),
    .en_i(irq_en_i), .flag_o(flags), .irq_o(irq_o)
  );

  assign cmp_flag_o  = flags[FLAG_CMP];
  assign edge_flag_o = flags[FLAG_EDGE];
endmodule

// File: rtl/trig_timer_ch_chk.sv
module trig_timer_ch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             enable_i,
  input logic [1:0]       irq_en_i,
  input logic [1:0]       flag_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cmp_flag_o,
  input logic             edge_flag_o,
  input logic             irq_o,
  input logic             out_o
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  // R1
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (cnt_o == '0));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o != $past(cnt_o)) |-> ((cnt_o == $past(cnt_o) + STEP) || (cnt_o == '0)));

  // R5
  cap_with_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_val_o != $past(cap_val_o)) |-> edge_flag_o);

  // R9
  cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_flag_o) |-> $past(flag_clr_i[0]));

  // R9
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(edge_flag_o) |-> $past(flag_clr_i[1]));

  // R8
  out_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i != 2'd2) || !enable_i) |=> !out_o);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_i == 2'b00) |-> !irq_o);
endmodule

bind trig_timer_ch trig_timer_ch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .enable_i(enable_i),
  .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i), .cnt_o(cnt_o),
  .cap_val_o(cap_val_o), .cmp_flag_o(cmp_flag_o), .edge_flag_o(edge_flag_o),
  .irq_o(irq_o), .out_o(out_o)
);

// File: tb/trig_timer_ch_tb_top.sv
`timescale 1ns/1ps
module trig_timer_ch_tb_top;
  localparam int W  = 8;
  localparam int PN = 4;
  localparam int MAXC = 1 << W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PN-1:0] pins_i;
  logic [1:0]    pin_sel_i;
  logic [1:0]    mode_i;
  logic          enable_i;
  logic [W-1:0]  cmp_val_i;
  logic          cap_en_i;
  logic [1:0]    irq_en_i;
  logic [1:0]    flag_clr_i;
  logic [W-1:0]  cnt_o, cap_val_o;
  logic          cmp_flag_o, edge_flag_o, irq_o, out_o;

  int nchk = 0;
  int nfail = 0;
  int e;
  bit done = 0;

  always #4 clk = ~clk;

  trig_timer_ch #(.CNT_W(W), .PIN_N(PN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .pin_sel_i(pin_sel_i),
    .mode_i(mode_i), .enable_i(enable_i), .cmp_val_i(cmp_val_i),
    .cap_en_i(cap_en_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .cnt_o(cnt_o), .cap_val_o(cap_val_o), .cmp_flag_o(cmp_flag_o),
    .edge_flag_o(edge_flag_o), .irq_o(irq_o), .out_o(out_o)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    e = e + 1;
  endtask

  // advancing edges t with lo < t < hi, odd t counted from the enable edge
  function automatic int ticks_between(input int lo, input int hi);
    int n = 0;
    for (int t = lo + 1; t < hi; t++) if (t > 0 && (t % 2) == 1) n++;
    return n;
  endfunction

  task automatic arm(input int md, input int cmp, input int sel, input bit cen);
    enable_i = 1'b0;
    step();
    mode_i = md[1:0]; cmp_val_i = cmp[W-1:0]; pin_sel_i = sel[1:0];
    cap_en_i = cen; flag_clr_i = 2'b11;
    step();
    flag_clr_i = 2'b00;
    enable_i = 1'b1;
    e = -1;
    step();
  endtask

  // drive a pulse of width p on pin pn after j idle edges; returns E0, E1
  task automatic pulse(input int pn, input int j, input int p, output int e0, output int e1);
    for (int k = 0; k < j; k++) step();
    pins_i[pn] = 1'b1;
    e0 = e + 1 + 2;
    for (int k = 0; k < p; k++) step();
    pins_i[pn] = 1'b0;
    e1 = e + 1 + 2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int e0, e1, cexp, tcmp, last_cap;
    rst_n = 1'b0; pins_i = '0; pin_sel_i = '0; mode_i = '0; enable_i = 1'b0;
    cmp_val_i = '0; cap_en_i = 1'b0; irq_en_i = '0; flag_clr_i = '0; e = 0;
    repeat (3) @(negedge clk);
    check("R11 cnt in reset", int'(cnt_o), 0);
    check("R11 out in reset", int'(out_o), 0);
    rst_n = 1'b1;
    step();
    check("R11 cap after reset", int'(cap_val_o), 0);
    check("R11 flags after reset", int'({cmp_flag_o, edge_flag_o, irq_o}), 0);

    // free mode sweep: R1 counting rate, R3 reload and compare flag
    for (int c = 0; c < 10; c++) begin
      arm(0, c, 0, 1'b0);
      while (e < 4 * (c + 1) + 2) begin
        check("R1 free count", int'(cnt_o), ((e + 1) / 2) % (c + 1));
        check("R3 compare flag", int'(cmp_flag_o), (e >= 2 * c + 1) ? 1 : 0);
        step();
      end
    end
    enable_i = 1'b0;
    step();
    check("R1 disabled clears", int'(cnt_o), 0);

    // R9 set wins over a held clear
    arm(0, 2, 0, 1'b0);
    flag_clr_i = 2'b01;
    step();
    while (e < 24) begin
      check("R9 set over clear", int'(cmp_flag_o),
            ((e % 2) == 1 && (((e + 1) / 2) % 3) == 0) ? 1 : 0);
      step();
    end
    flag_clr_i = 2'b00;

    // R9/R10 sticky flag, masking and clear
    arm(0, 1, 0, 1'b0);
    repeat (6) step();
    enable_i = 1'b0;
    step(); step();
    check("R9 flag sticky", int'(cmp_flag_o), 1);
    irq_en_i = 2'b10; #1;
    check("R10 irq masked", int'(irq_o), 0);
    irq_en_i = 2'b01; #1;
    check("R10 irq enabled", int'(irq_o), 1);
    flag_clr_i = 2'b10;
    step();
    check("R9 wrong bit keeps flag", int'(cmp_flag_o), 1);
    flag_clr_i = 2'b01;
    step();
    flag_clr_i = 2'b00;
    check("R9 clear flag", int'(cmp_flag_o), 0);
    check("R10 irq drops", int'(irq_o), 0);
    irq_en_i = 2'b00;

    // R2/R4/R5 capture sweep over pins, prescaler phase and width
    for (int sel = 0; sel < PN; sel++)
      for (int j = 0; j < 2; j++)
        for (int p = 1; p < 10; p++) begin
          arm(1, 200, sel, 1'b1);
          pulse(sel, j, p, e0, e1);
          while (e < e1 - 1) step();
          check("R5 no flag before fall", int'(edge_flag_o), 0);
          step();
          cexp = ticks_between(e0, e1);
          check("R5 capture value", int'(cap_val_o), cexp);
          check("R5 edge flag", int'(edge_flag_o), 1);
          check("R4 counter stops", int'(cnt_o), cexp);
          check("R8 out idle in capture", int'(out_o), 0);
          last_cap = cexp;
        end

    // R4 armed counter holds at zero
    arm(1, 200, 0, 1'b1);
    repeat (8) step();
    check("R4 armed holds", int'(cnt_o), 0);

    // R2 unselected pin ignored
    pulse(2, 0, 5, e0, e1);
    repeat (6) step();
    check("R2 other pin flag", int'(edge_flag_o), 0);
    check("R2 other pin cnt", int'(cnt_o), 0);
    check("R2 other pin cap", int'(cap_val_o), last_cap);

    // R5 capture disabled
    arm(3, 200, 1, 1'b0);
    pulse(1, 0, 7, e0, e1);
    while (e < e1 + 1) step();
    check("R5 cap disabled value", int'(cap_val_o), last_cap);
    check("R5 cap disabled flag", int'(edge_flag_o), 0);

    // R6 wrap without falling edge
    arm(1, MAXC - 1, 0, 1'b1);
    pins_i[0] = 1'b1;
    e0 = e + 3;
    while (e < e0 + 2 * MAXC + 6) begin
      step();
      if (e >= e0)
        check("R6 wrap count", int'(cnt_o), ticks_between(e0, e + 1) % MAXC);
    end
    check("R6 no capture", int'(edge_flag_o), 0);
    pins_i[0] = 1'b0;
    repeat (4) step();

    // R7/R8 pulse shortening sweep
    for (int c = 0; c < 5; c++)
      for (int p = 1; p < 11; p++) begin
        arm(2, c, 0, 1'b0);
        pins_i[0] = 1'b1;
        e0 = e + 3;
        tcmp = (e0 % 2 == 1) ? e0 + 2 : e0 + 1;
        tcmp = tcmp + 2 * c;
        e1 = e + 1 + p + 2;
        while (e < e1 + 1) begin
          if (e == e + 1 - p - 1 + p) ; // keep pin timing in one place below
          step();
          if (e == e1 - 3) pins_i[0] = 1'b0;
          check("R8 shaped out", int'(out_o),
                (e >= tcmp && tcmp < e1 && e < e1) ? 1 : 0);
        end
        check("R7 compare in triggered", int'(cmp_flag_o), (tcmp < e1) ? 1 : 0);
      end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule